// File: doc/BRIEF.md
# Synchronous Serial Port with Block Transfer

This block is a clocked synchronous serial shifter that moves a programmed run of bits, anywhere from 1 to 256, between a serial line and a local byte buffer. Before a transfer, the host fills the buffer through a plain byte read/write port. It then picks the bit order and the clock source, sets the length, and pulses `run_start`. The engine fetches one byte at a time into its shift register. It shifts that byte out on `so` while shifting `si` in. It writes each received byte back to the same buffer slot before it moves to the next slot.

The port can generate the serial clock from an internal divider, or it can follow an external clock on `sck_in`. The serial clock idles high. Transmit data changes after a falling edge, and receive data is sampled on a rising edge. Between bytes the clock is held high while the engine stores one byte and fetches the next. A hold request can park the transfer at any byte boundary. When the last bit has been shifted, the run flag `busy` clears itself and `done_irq` rises.

The buffer port has no flow control. It is a plain synchronous memory port, and an engine store takes priority over a host write to the same cycle. The configuration inputs must stay stable while `busy` is high.

Top module: `sync_block_sio`

## Requirements
- R1: Out of reset, `busy` and `done_irq` are 0 and `sck_out` and `so` are 1. Whenever `busy` is 0, `sck_out` is 1, and `sck_oe` equals the inverse of `cfg_ext_clk`.
- R2: A `run_start` pulse while idle raises `busy` on the next cycle. At the end of the transfer, `busy` falls in the same cycle that `done_irq` becomes 1. `done_irq` stays set until `irq_clr` is pulsed.
- R3: A transfer moves exactly `cfg_len_m1`+1 bits, so that 0 gives 1 bit and 255 gives 256 bits. It produces exactly that many serial clock cycles and then stops.
- R4: With `cfg_msb_first`=1, each buffer byte is sent bit 7 first. With `cfg_msb_first`=0, it is sent bit 0 first. Bytes are sent from buffer address 0 upward.
- R5: In master mode, `so` changes only while `sck_out` is low, right after a falling edge. `si` is captured on the rising edge.
- R6: Each received group of 8 bits is written to the buffer slot its transmit byte came from. With MSB first, the first bit received lands in bit 7. With LSB first, it lands in bit 0.
- R7: A final partial byte of k bits is stored right-aligned in bits k-1..0, with the upper bits zero. With MSB first, the first bit received is at bit k-1. With LSB first, it is at bit 0. Buffer slots beyond the last byte touched keep their contents.
- R8: In master mode, each half-period of `sck_out` lasts `cfg_baud_div`+1 system clock cycles.
- R9: Between bytes, the serial clock stays high. If `hold_req` is 1 when a byte completes, the transfer parks with `sck_out` high and `busy` still 1. It resumes without losing a bit after `hold_req` returns to 0.
- R10: With `cfg_ext_clk`=1, bits move on the edges of `sck_in`, seen through a two-flop synchronizer, and `sck_out` stays high. The first falling edge on `sck_in` must come at least 3 system cycles after `run_start`. At each byte boundary, `sck_in` must stay high for at least 3 cycles after its rising edge.
- R11: A `run_start` pulse while `busy` is 1 is ignored, and the transfer in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_msb_first | input | 1 | 1: bit 7 first, 0: bit 0 first |
| cfg_ext_clk | input | 1 | 1: follow `sck_in`, 0: generate the clock internally |
| cfg_baud_div | input | DIV_W | Half-period of the master clock minus one, in system cycles |
| cfg_len_m1 | input | LEN_W | Bit count minus one |
| run_start | input | 1 | Single-cycle start pulse |
| hold_req | input | 1 | Park the transfer at the next byte boundary |
| irq_clr | input | 1 | Clear `done_irq` |
| busy | output | 1 | Run flag; clears itself at the end of the transfer |
| done_irq | output | 1 | Completion flag |
| buf_we | input | 1 | Host buffer write enable |
| buf_addr | input | AW | Host buffer address |
| buf_wdata | input | 8 | Host write data |
| buf_rdata | output | 8 | Host read data (combinational read) |
| sck_in | input | 1 | External serial clock |
| sck_out | output | 1 | Serial clock driven by this port |
| sck_oe | output | 1 | Serial clock output enable |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |

## Verification
A wrong bit counter or byte pointer shows up as a count of serial clocks that differs from the programmed length. It also shows up as a misplaced or shifted byte in the buffer readback, which is visible as soon as `busy` falls. A wrong bit-order select or shift direction corrupts the first captured `so` bit and the first stored byte. A bad alignment of the partial final byte shows only in the last slot and in the slot after it. Divider or gap errors appear within the first serial clock period as a wrong measured half-period, or as a clock that does not stay high during a hold.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SHIFT,
    ST_STORE,
    ST_HOLD
  } sio_state_e;

  // Right-align a partially filled receive byte of k bits (1..8).
  function automatic logic [7:0] align_rx(input logic [7:0] sh,
                                          input logic [3:0] k,
                                          input logic       msb);
    logic [7:0] mask;
    mask = 8'hFF >> (4'd8 - k);
    if (msb) return sh & mask;
    return (sh >> (4'd8 - k)) & mask;
  endfunction
endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!en)        cnt <= '0;
    else if (cnt == div) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == div);
endmodule

// File: rtl/sio_sync_edge.sv
module sio_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  input  logic si_in,
  output logic si_s,
  output logic fall,
  output logic rise
);
  logic [STAGES-1:0] sck_q;
  logic [STAGES-1:0] si_q;
  logic              sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= '1;
      si_q     <= '0;
      sck_prev <= 1'b1;
    end else begin
      sck_q    <= {sck_q[STAGES-2:0], sck_in};
      si_q     <= {si_q[STAGES-2:0], si_in};
      sck_prev <= sck_q[STAGES-1];
    end
  end

  assign si_s = si_q[STAGES-1];
  assign fall = sck_prev & ~sck_q[STAGES-1];
  assign rise = ~sck_prev & sck_q[STAGES-1];
endmodule

// File: rtl/sio_buffer.sv
module sio_buffer #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [7:0]    a_wdata,
  output logic [7:0]    a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [7:0]    b_wdata,
  output logic [7:0]    b_rdata
);
  logic [7:0] mem [DEPTH];

  // Port a (engine) wins over port b (host) in the same cycle.
  always_ff @(posedge clk) begin
    if (a_we)      mem[a_addr] <= a_wdata;
    else if (b_we) mem[b_addr] <= b_wdata;
  end

  assign a_rdata = mem[a_addr];
  assign b_rdata = mem[b_addr];
endmodule

// File: rtl/sync_block_sio.sv
module sync_block_sio #(
  parameter int BUF_BYTES   = 32,
  parameter int LEN_W       = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(BUF_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_msb_first,
  input  logic             cfg_ext_clk,
  input  logic [DIV_W-1:0] cfg_baud_div,
  input  logic [LEN_W-1:0] cfg_len_m1,
  input  logic             run_start,
  input  logic             hold_req,
  input  logic             irq_clr,
  output logic             busy,
  output logic             done_irq,
  input  logic             buf_we,
  input  logic [AW-1:0]    buf_addr,
  input  logic [7:0]       buf_wdata,
  output logic [7:0]       buf_rdata,
  input  logic             sck_in,
  output logic             sck_out,
  output logic             sck_oe,
  input  logic             si,
  output logic             so
);
  import sio_pkg::*;

  sio_state_e       state;
  logic [7:0]       sh;
  logic [3:0]       nbits;
  logic [LEN_W-1:0] left;
  logic [AW-1:0]    ptr;
  logic             last_q, sck_q, so_q, done_q;
  logic             master, tick, ext_fall, ext_rise, si_sync, si_bit;
  logic             fall_ev, rise_ev;
  logic [7:0]       eng_rdata;

  assign master = ~cfg_ext_clk;

  sio_baud #(.DIV_W(DIV_W)) i_baud (
    .clk(clk), .rst_n(rst_n),
    .en(master && state == ST_SHIFT),
    .div(cfg_baud_div), .tick(tick)
  );

  sio_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .sck_in(sck_in), .si_in(si),
    .si_s(si_sync), .fall(ext_fall), .rise(ext_rise)
  );

  sio_buffer #(.DEPTH(BUF_BYTES), .AW(AW)) i_buf (
    .clk(clk),
    .a_we(state == ST_STORE), .a_addr(ptr),
    .a_wdata(align_rx(sh, nbits, cfg_msb_first)), .a_rdata(eng_rdata),
    .b_we(buf_we), .b_addr(buf_addr), .b_wdata(buf_wdata), .b_rdata(buf_rdata)
  );

  assign si_bit  = master ? si : si_sync;
  assign fall_ev = master ? (tick & sck_q)  : ext_fall;
  assign rise_ev = master ? (tick & ~sck_q) : ext_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      sh     <= '0;
      nbits  <= '0;
      left   <= '0;
      ptr    <= '0;
      last_q <= 1'b0;
      sck_q  <= 1'b1;
      so_q   <= 1'b1;
      done_q <= 1'b0;
    end else begin
      if (irq_clr) done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (run_start) begin
          ptr    <= '0;
          nbits  <= '0;
          left   <= cfg_len_m1;
          last_q <= 1'b0;
          state  <= ST_LOAD;
        end
        ST_LOAD: begin
          sh    <= eng_rdata;
          state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (master && tick) sck_q <= ~sck_q;
          if (fall_ev) so_q <= cfg_msb_first ? sh[7] : sh[0];
          if (rise_ev) begin
            sh    <= cfg_msb_first ? {sh[6:0], si_bit} : {si_bit, sh[7:1]};
            nbits <= nbits + 1'b1;
            if (left == '0) last_q <= 1'b1;
            else            left   <= left - 1'b1;
            if (left == '0 || nbits == 4'd7) state <= ST_STORE;
          end
        end
        ST_STORE: begin
          if (last_q) begin
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            ptr   <= ptr + 1'b1;
            nbits <= '0;
            state <= hold_req ? ST_HOLD : ST_LOAD;
          end
        end
        ST_HOLD: if (!hold_req) state <= ST_LOAD;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign done_irq = done_q;
  assign sck_out  = sck_q;
  assign sck_oe   = master;
  assign so       = so_q;
endmodule

// File: rtl/sio_checker.sv
module sio_checker (
  input logic clk,
  input logic rst_n,
  input logic run_start,
  input logic busy,
  input logic done_irq,
  input logic sck_out,
  input logic so,
  input logic cfg_ext_clk
);
  AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck_out); // R1

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (run_start && !busy) |=> busy); // R2

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_irq); // R2

  AST_SO_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ext_clk && !$stable(so)) |-> !sck_out); // R5

  AST_EXT_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ext_clk && $stable(cfg_ext_clk) && sck_out) |=> sck_out); // R10
endmodule

bind sync_block_sio sio_checker i_sio_checker (
  .clk(clk), .rst_n(rst_n), .run_start(run_start), .busy(busy),
  .done_irq(done_irq), .sck_out(sck_out), .so(so), .cfg_ext_clk(cfg_ext_clk)
);

// File: tb/test_sync_block_sio.sv
module test_sync_block_sio;
  localparam int NB = 32;
  localparam int AW = $clog2(NB);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_msb_first = 1'b0, cfg_ext_clk = 1'b0;
  logic [7:0]    cfg_baud_div = '0, cfg_len_m1 = '0;
  logic          run_start = 1'b0, hold_req = 1'b0, irq_clr = 1'b0;
  logic          busy, done_irq, sck_out, sck_oe, so;
  logic          buf_we = 1'b0;
  logic [AW-1:0] buf_addr = '0;
  logic [7:0]    buf_wdata = '0, buf_rdata;
  logic          bench_sck = 1'b1;
  logic          si = 1'b0;

  sync_block_sio i_sync_block_sio (
    .clk(clk), .rst_n(rst_n), .cfg_msb_first(cfg_msb_first),
    .cfg_ext_clk(cfg_ext_clk), .cfg_baud_div(cfg_baud_div),
    .cfg_len_m1(cfg_len_m1), .run_start(run_start), .hold_req(hold_req),
    .irq_clr(irq_clr), .busy(busy), .done_irq(done_irq), .buf_we(buf_we),
    .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .sck_in(bench_sck), .sck_out(sck_out), .sck_oe(sck_oe), .si(si), .so(so)
  );

  always #5 clk = ~clk;

  int vecs = 0, fails = 0, cyc = 0;
  logic [7:0] tx_img [NB];
  bit slave_bits [256];
  bit got_so [256];
  int si_idx, so_idx;
  bit active = 1'b0;
  time t_fall, t_rise;
  wire sck_line = cfg_ext_clk ? bench_sck : sck_out;

  // Slave model: present next bit after a falling edge, capture SO on a rising edge.
  always @(negedge sck_line) if (active) begin
    if (si_idx < 256) si <= slave_bits[si_idx];
    si_idx++;
    if (t_fall == 0) t_fall = $time;
  end
  always @(posedge sck_line) if (active) begin
    if (so_idx < 256) got_so[so_idx] = so;
    so_idx++;
    if (t_rise == 0 && t_fall != 0) t_rise = $time;
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_so_bit(input int i, input bit msb);
    logic [7:0] b;
    b = tx_img[i / 8];
    return msb ? b[7 - (i % 8)] : b[i % 8];
  endfunction

  function automatic logic [7:0] exp_rx(input int bi, input int k, input bit msb);
    logic [7:0] r;
    r = '0;
    for (int j = 0; j < k; j++)
      if (msb) r[k - 1 - j] = slave_bits[bi * 8 + j];
      else     r[j]         = slave_bits[bi * 8 + j];
    return r;
  endfunction

  task automatic write_buf;
    for (int a = 0; a < NB; a++) begin
      tx_img[a] = 8'($urandom);
      @(negedge clk);
      buf_we = 1'b1; buf_addr = AW'(a); buf_wdata = tx_img[a];
    end
    @(negedge clk);
    buf_we = 1'b0;
  endtask

  task automatic run_xfer(input int nbits, input bit msb, input bit ext,
                          input int div, input bit use_hold, input bit poke);
    int t, nfull, rem, bad;
    write_buf();
    for (int i = 0; i < 256; i++) slave_bits[i] = 1'($urandom);
    cfg_msb_first = msb; cfg_ext_clk = ext;
    cfg_baud_div = 8'(div); cfg_len_m1 = 8'(nbits - 1);
    si_idx = 0; so_idx = 0; t_fall = 0; t_rise = 0; active = 1'b1;
    hold_req = use_hold;
    @(negedge clk); run_start = 1'b1;
    @(negedge clk); run_start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    chk(sck_oe == !ext, "R1 sck_oe", int'(sck_oe), int'(!ext));
    if (ext) begin
      repeat (4) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
        bench_sck = 1'b0; #60;
        bench_sck = 1'b1; #60;
        if (i % 8 == 7) #60;
      end
    end else begin
      if (poke) begin
        t = 0;
        while (so_idx < 3 && t < 20000) begin @(negedge clk); t++; end
        run_start = 1'b1; @(negedge clk); run_start = 1'b0;
      end
      if (use_hold) begin
        t = 0;
        while (so_idx < 8 && t < 20000) begin @(negedge clk); t++; end
        repeat (30) @(negedge clk);
        chk(busy == 1'b1, "R9 busy during hold", int'(busy), 1);
        chk(sck_out == 1'b1, "R9 sck high during hold", int'(sck_out), 1);
        chk(so_idx == 8, "R9 no clocks during hold", so_idx, 8);
        hold_req = 1'b0;
      end
    end
    t = 0;
    while (busy && t < 40000) begin @(negedge clk); t++; end
    repeat (2) @(negedge clk);
    active = 1'b0;
    chk(busy == 1'b0, "R2 busy cleared", int'(busy), 0);
    chk(done_irq == 1'b1, "R2 done set", int'(done_irq), 1);
    chk(sck_out == 1'b1, "R1 sck idles high", int'(sck_out), 1);
    chk(so_idx == nbits, poke ? "R11 restart ignored, bit count" :
        (ext ? "R10 ext bit count" : "R3 bit count"), so_idx, nbits);
    bad = 0;
    for (int i = 0; i < nbits && i < 256; i++)
      if (got_so[i] != exp_so_bit(i, msb)) bad++;
    chk(bad == 0, msb ? "R4 R5 msb-first SO stream" : "R4 R5 lsb-first SO stream", bad, 0);
    if (!ext && nbits > 1)
      chk((t_rise - t_fall) == time'((div + 1) * 10), "R8 half period",
          int'(t_rise - t_fall), (div + 1) * 10);
    nfull = nbits / 8; rem = nbits % 8;
    for (int b = 0; b < nfull; b++) begin
      buf_addr = AW'(b); #1;
      chk(buf_rdata == exp_rx(b, 8, msb), "R6 R5 full byte stored",
          int'(buf_rdata), int'(exp_rx(b, 8, msb)));
    end
    if (rem != 0) begin
      buf_addr = AW'(nfull); #1;
      chk(buf_rdata == exp_rx(nfull, rem, msb), "R7 partial byte aligned",
          int'(buf_rdata), int'(exp_rx(nfull, rem, msb)));
    end
    t = (nbits + 7) / 8;
    if (t < NB) begin
      buf_addr = AW'(t); #1;
      chk(buf_rdata == tx_img[t], "R7 slot past end untouched",
          int'(buf_rdata), int'(tx_img[t]));
    end
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk(done_irq == 1'b0, "R2 done cleared", int'(done_irq), 0);
  endtask

  initial begin
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    chk(done_irq == 1'b0, "R1 reset done", int'(done_irq), 0);
    chk(sck_out == 1'b1, "R1 reset sck", int'(sck_out), 1);
    chk(so == 1'b1, "R1 reset so", int'(so), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_xfer(1, 1'b1, 1'b0, 0, 1'b0, 1'b0);
    run_xfer(256, 1'b0, 1'b0, 0, 1'b0, 1'b0);
    run_xfer(8, 1'b1, 1'b0, 2, 1'b0, 1'b0);
    run_xfer(19, 1'b0, 1'b0, 1, 1'b1, 1'b0);
    run_xfer(30, 1'b1, 1'b0, 3, 1'b0, 1'b1);
    run_xfer(13, 1'b1, 1'b1, 0, 1'b0, 1'b0);
    run_xfer(20, 1'b0, 1'b1, 0, 1'b0, 1'b0);
    for (int r = 0; r < 8; r++) begin
      int nb, dv;
      bit ex, ms, hd;
      ex = ($urandom % 3) == 0;
      nb = ex ? 1 + int'($urandom % 40) : 1 + int'($urandom % 256);
      dv = int'($urandom % 4);
      ms = 1'($urandom);
      hd = !ex && nb > 8 && 1'($urandom);
      run_xfer(nb, ms, ex, dv, hd, 1'b0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule